// File: doc/BRIEF.md
# Nibble-Coded Stored-Program Byte Processor

This block is a small stored-program processor with 8-bit data. Programs and data share one 256-byte memory. Every instruction is 16 bits wide and is held as two bytes. The machine has sixteen 8-bit general registers, a program counter and an instruction register. For each instruction it walks through four states: high-byte fetch, low-byte fetch, decode, and execute with writeback. It supports five operations: load a register from memory, load a register with a constant, store a register to memory, add two registers into a third, and halt.

The machine stays idle after reset until a start pulse arrives. While it is idle or halted, the testbench places a program in memory through a debug port. The same port reads back any register and any memory byte. When the machine reaches a halt instruction, or any opcode it does not implement, it stops and raises a halted status. An unimplemented opcode also raises an illegal-opcode flag. After that, only reset brings the machine back.

Top module: `nib_cpu`

## Requirements
- R1: After reset, all sixteen registers read 0x00, the program counter is 0x00, and both halted_o and illegal_o are low.
- R2: After reset the machine does nothing until start_i is sampled high. Register and memory contents do not change while it waits.
- R3: An instruction occupies two bytes. The high byte is at the even address in the program counter and the low byte is at the next address. The program counter advances by 2 after each fetch.
- R4: Instruction bits [15:12] hold the opcode and bits [11:8] name register R. Bits [7:0] hold either an address or constant XY, or two source registers: S in bits [7:4] and T in bits [3:0].
- R5: Opcode 0x1 copies the memory byte at address XY into register R.
- R6: Opcode 0x2 loads register R with the constant XY.
- R7: Opcode 0x3 writes register R into memory at address XY.
- R8: Opcode 0x5 writes (S + T) mod 256 into R. For example, 0x5C + 0x5A gives 0xB6 and 0xFF + 0x02 gives 0x01.
- R9: An add may name the same register as R, S and T. In that case it uses the register's value from before the instruction, so 0x40 becomes 0x80.
- R10: Opcodes 0x0, 0x4, 0x6 to 0xB, and 0xD to 0xF set illegal_o and halted_o. They do not change any register or memory byte.
- R11: Opcode 0xC sets halted_o and leaves illegal_o low. Take N as the number of instructions that come before the halt. Counting the clock edge that samples start as the first edge, halted_o is high after edge 4N+4. An illegal opcode halts at the same point.
- R12: Once halted, the machine ignores start_i and executes nothing further until reset.
- R13: The debug port reads any register and any memory byte combinationally, and writes memory bytes. If a debug write and an executing store hit memory in the same cycle, the store wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins execution from an idle machine |
| halted_o | output | 1 | Machine has stopped |
| illegal_o | output | 1 | Stop was caused by an unimplemented opcode |
| dbg_reg_sel_i | input | 4 | Register chosen for debug read |
| dbg_reg_o | output | 8 | Value of the chosen register |
| dbg_addr_i | input | 8 | Memory address for debug read or write |
| dbg_mem_o | output | 8 | Memory byte at dbg_addr_i |
| dbg_we_i | input | 1 | Debug memory write enable |
| dbg_wdata_i | input | 8 | Debug memory write data |

## Verification
In the execute cycle, register reads and the register write fall in the same cycle. The bench provokes this with an add that names one register as R, S and T, starting from 0x40. Reading the new value would give a different result from the correct 0x80, so a bypass fault shows up. Separate programs cover the example sum, wraparound, every illegal opcode, the halt timing, and the rule that start is ignored once halted.

// File: rtl/nib_pkg.sv
package nib_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FHI, ST_FLO, ST_DEC, ST_EXE, ST_HALT
  } state_e;

  localparam logic [3:0] OP_LDM = 4'h1;
  localparam logic [3:0] OP_LDI = 4'h2;
  localparam logic [3:0] OP_STM = 4'h3;
  localparam logic [3:0] OP_ADD = 4'h5;
  localparam logic [3:0] OP_HLT = 4'hC;

  function automatic logic op_legal(logic [3:0] op);
    return (op == OP_LDM) || (op == OP_LDI) || (op == OP_STM) ||
           (op == OP_ADD) || (op == OP_HLT);
  endfunction
endpackage

// File: rtl/nib_mem.sv
module nib_mem #(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic [AW-1:0] core_addr_i,
  output logic [DW-1:0] core_rdata_o,
  input  logic          core_we_i,
  input  logic [DW-1:0] core_wdata_i,
  input  logic [AW-1:0] dbg_addr_i,
  output logic [DW-1:0] dbg_rdata_o,
  input  logic          dbg_we_i,
  input  logic [DW-1:0] dbg_wdata_i
);
  logic [DW-1:0] mem_q [DEPTH];

  // core store has priority over a colliding debug write
  always_ff @(posedge clk_i) begin
    if (core_we_i)     mem_q[core_addr_i] <= core_wdata_i;
    else if (dbg_we_i) mem_q[dbg_addr_i]  <= dbg_wdata_i;
  end

  assign core_rdata_o = mem_q[core_addr_i];
  assign dbg_rdata_o  = mem_q[dbg_addr_i];
endmodule

// File: rtl/nib_regfile.sv
module nib_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ra_addr_i,
  output logic [DW-1:0] ra_o,
  input  logic [IW-1:0] rb_addr_i,
  output logic [DW-1:0] rb_o,
  input  logic [IW-1:0] rc_addr_i,
  output logic [DW-1:0] rc_o,
  input  logic [IW-1:0] dbg_addr_i,
  output logic [DW-1:0] dbg_o
);
  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  // reads return pre-write values (no bypass)
  assign ra_o  = regs_q[ra_addr_i];
  assign rb_o  = regs_q[rb_addr_i];
  assign rc_o  = regs_q[rc_addr_i];
  assign dbg_o = regs_q[dbg_addr_i];

  p_write_lands_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/nib_exec.sv
module nib_exec
  import nib_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] xy_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] rs_i,
  input  logic [DW-1:0] rt_i,
  output logic          reg_we_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          mem_we_o
);
  always_comb begin
    reg_we_o    = 1'b0;
    reg_wdata_o = '0;
    mem_we_o    = 1'b0;
    unique case (op_i)
      OP_LDM: begin reg_we_o = 1'b1; reg_wdata_o = mem_rdata_i; end
      OP_LDI: begin reg_we_o = 1'b1; reg_wdata_o = xy_i; end
      OP_STM: mem_we_o = 1'b1;
      OP_ADD: begin reg_we_o = 1'b1; reg_wdata_o = rs_i + rt_i; end
      default: ;
    endcase
  end
endmodule

// File: rtl/nib_cpu.sv
module nib_cpu
  import nib_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          halted_o,
  output logic          illegal_o,
  input  logic [IW-1:0] dbg_reg_sel_i,
  output logic [DW-1:0] dbg_reg_o,
  input  logic [AW-1:0] dbg_addr_i,
  output logic [DW-1:0] dbg_mem_o,
  input  logic          dbg_we_i,
  input  logic [DW-1:0] dbg_wdata_i
);
  state_e        state_q, state_d;
  logic [AW-1:0] pc_q;
  logic [15:0]   ir_q;
  logic          illegal_q;

  logic [3:0]    op;
  logic [IW-1:0] fld_r, fld_s, fld_t;
  logic [DW-1:0] fld_xy;
  assign op     = ir_q[15:12];
  assign fld_r  = ir_q[8 +: IW];
  assign fld_xy = ir_q[7:0];
  assign fld_s  = ir_q[4 +: IW];
  assign fld_t  = ir_q[0 +: IW];

  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata, rs, rt, rr, ex_wdata;
  logic          ex_reg_we, ex_mem_we, reg_we, mem_we;

  always_comb begin
    unique case (state_q)
      ST_FHI:  mem_addr = pc_q;
      ST_FLO:  mem_addr = pc_q + AW'(1);
      default: mem_addr = fld_xy;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_FHI;
      ST_FHI:  state_d = ST_FLO;
      ST_FLO:  state_d = ST_DEC;
      ST_DEC:  state_d = (!op_legal(op) || op == OP_HLT) ? ST_HALT : ST_EXE;
      ST_EXE:  state_d = ST_FHI;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pc_q      <= '0;
      ir_q      <= '0;
      illegal_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_FHI) ir_q[15:8] <= mem_rdata;
      if (state_q == ST_FLO) begin
        ir_q[7:0] <= mem_rdata;
        pc_q      <= pc_q + AW'(2);
      end
      if (state_q == ST_DEC && !op_legal(op)) illegal_q <= 1'b1;
    end
  end

  assign reg_we = (state_q == ST_EXE) && ex_reg_we;
  assign mem_we = (state_q == ST_EXE) && ex_mem_we;

  nib_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i        (clk_i),
    .core_addr_i  (mem_addr),
    .core_rdata_o (mem_rdata),
    .core_we_i    (mem_we),
    .core_wdata_i (rr),
    .dbg_addr_i   (dbg_addr_i),
    .dbg_rdata_o  (dbg_mem_o),
    .dbg_we_i     (dbg_we_i),
    .dbg_wdata_i  (dbg_wdata_i)
  );

  nib_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we),
    .waddr_i    (fld_r),
    .wdata_i    (ex_wdata),
    .ra_addr_i  (fld_s),
    .ra_o       (rs),
    .rb_addr_i  (fld_t),
    .rb_o       (rt),
    .rc_addr_i  (fld_r),
    .rc_o       (rr),
    .dbg_addr_i (dbg_reg_sel_i),
    .dbg_o      (dbg_reg_o)
  );

  nib_exec #(.DW(DW)) u_exec (
    .op_i        (op),
    .xy_i        (fld_xy),
    .mem_rdata_i (mem_rdata),
    .rs_i        (rs),
    .rt_i        (rt),
    .reg_we_o    (ex_reg_we),
    .reg_wdata_o (ex_wdata),
    .mem_we_o    (ex_mem_we)
  );

  assign halted_o  = (state_q == ST_HALT);
  assign illegal_o = illegal_q;

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> state_q == ST_IDLE);
  p_pc_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FLO) |=> pc_q == AW'($past(pc_q) + AW'(2)));
  p_fetch_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FHI) |=> state_q == ST_FLO);
  p_illegal_halts_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> halted_o);
  p_halt_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(pc_q) && $stable(ir_q));
endmodule

// File: tb/sim_nib_cpu.sv
`timescale 1ns/1ps
module sim_nib_cpu;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start = 1'b0;
  logic       halted, illegal;
  logic [3:0] reg_sel = '0;
  logic [7:0] reg_val, dbg_addr = '0, mem_val, dbg_wdata = '0;
  logic       dbg_we = 1'b0;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  nib_cpu u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .halted_o(halted), .illegal_o(illegal),
    .dbg_reg_sel_i(reg_sel), .dbg_reg_o(reg_val),
    .dbg_addr_i(dbg_addr), .dbg_mem_o(mem_val),
    .dbg_we_i(dbg_we), .dbg_wdata_i(dbg_wdata)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; start = 1'b0; dbg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic mem_wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    dbg_addr = a; dbg_wdata = d; dbg_we = 1'b1;
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic rd_reg(logic [3:0] r, output int v);
    reg_sel = r; #1; v = reg_val;
  endtask

  task automatic rd_mem(logic [7:0] a, output int v);
    dbg_addr = a; #1; v = mem_val;
  endtask

  // returns edges counted from the one sampling start up to halted seen
  task automatic run(output int cyc);
    cyc = 0;
    @(negedge clk); start = 1'b1;
    @(posedge clk); cyc++;
    @(negedge clk); start = 1'b0;
    while (!halted && cyc < 1000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_idle();
    int v;
    do_reset();
    chk("R1", "halted", halted, 0);
    chk("R1", "illegal", illegal, 0);
    for (int r = 0; r < 16; r++) begin
      rd_reg(r[3:0], v); chk("R1", "reg", v, 0);
    end
    mem_wr(8'h00, 8'h25); mem_wr(8'h01, 8'h99); mem_wr(8'h02, 8'hC0);
    mem_wr(8'h03, 8'h00);
    repeat (10) @(negedge clk);
    rd_reg(4'h5, v); chk("R2", "no exec before start r5", v, 0);
    chk("R2", "not halted while idle", halted, 0);
  endtask

  task automatic t_example();
    int v, cyc;
    do_reset();
    mem_wr(8'h40, 8'h5C); mem_wr(8'h41, 8'h5A);
    mem_wr(8'h00, 8'h15); mem_wr(8'h01, 8'h40);
    mem_wr(8'h02, 8'h16); mem_wr(8'h03, 8'h41);
    mem_wr(8'h04, 8'h50); mem_wr(8'h05, 8'h56);
    mem_wr(8'h06, 8'h30); mem_wr(8'h07, 8'h42);
    mem_wr(8'h08, 8'h2A); mem_wr(8'h09, 8'h7E);
    mem_wr(8'h0A, 8'hC0); mem_wr(8'h0B, 8'h00);
    run(cyc);
    chk("R11", "halt cycle count", cyc, 4*5+4);
    chk("R11", "halted", halted, 1);
    chk("R11", "no illegal on halt", illegal, 0);
    rd_reg(4'h5, v); chk("R5", "load mem r5", v, 8'h5C);
    rd_reg(4'h6, v); chk("R5", "load mem r6", v, 8'h5A);
    rd_reg(4'h0, v); chk("R8", "sum r0", v, 8'hB6);
    rd_mem(8'h42, v); chk("R7", "store mem42", v, 8'hB6);
    rd_reg(4'hA, v); chk("R6", "imm rA", v, 8'h7E);
    rd_reg(4'h1, v); chk("R4", "untouched r1", v, 0);
  endtask

  task automatic t_wrap_same_reg_illegal();
    int v, cyc;
    do_reset();
    mem_wr(8'h00, 8'h2F); mem_wr(8'h01, 8'hFF);
    mem_wr(8'h02, 8'h21); mem_wr(8'h03, 8'h02);
    mem_wr(8'h04, 8'h53); mem_wr(8'h05, 8'hF1);
    mem_wr(8'h06, 8'h24); mem_wr(8'h07, 8'h40);
    mem_wr(8'h08, 8'h54); mem_wr(8'h09, 8'h44);
    mem_wr(8'h0A, 8'h60); mem_wr(8'h0B, 8'h00);
    mem_wr(8'h0C, 8'h2B); mem_wr(8'h0D, 8'h11);
    run(cyc);
    chk("R10", "illegal halt cycles", cyc, 4*5+4);
    chk("R10", "illegal flag", illegal, 1);
    chk("R10", "halted", halted, 1);
    rd_reg(4'h3, v); chk("R8", "wrap FF+02", v, 8'h01);
    rd_reg(4'h4, v); chk("R9", "r4=r4+r4", v, 8'h80);
    rd_reg(4'hB, v); chk("R10", "no exec past illegal", v, 0);
    rd_reg(4'h0, v); chk("R10", "illegal no write r0", v, 0);
    // R12: start after halt must not rerun (r1 would become 77)
    mem_wr(8'h03, 8'h77);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (12) @(negedge clk);
    rd_reg(4'h1, v); chk("R12", "no rerun r1", v, 8'h02);
    chk("R12", "still halted", halted, 1);
  endtask

  task automatic t_all_illegal();
    int v, cyc;
    logic [3:0] ops [11] = '{4'h0, 4'h4, 4'h6, 4'h7, 4'h8, 4'h9,
                             4'hA, 4'hB, 4'hD, 4'hE, 4'hF};
    for (int k = 0; k < 11; k++) begin
      do_reset();
      mem_wr(8'h55, 8'h33);
      mem_wr(8'h00, {ops[k], 4'h1}); mem_wr(8'h01, 8'h55);
      run(cyc);
      chk("R10", $sformatf("op %0h cycles", ops[k]), cyc, 4);
      chk("R10", $sformatf("op %0h flag", ops[k]), illegal, 1);
      rd_reg(4'h1, v); chk("R10", $sformatf("op %0h r1", ops[k]), v, 0);
      rd_mem(8'h55, v); chk("R10", $sformatf("op %0h mem", ops[k]), v, 8'h33);
    end
  endtask

  task automatic t_fetch_order();
    int v, cyc;
    // R3: bytes reversed would decode as opcode 4 (illegal)
    do_reset();
    mem_wr(8'h00, 8'h27); mem_wr(8'h01, 8'h4D);
    mem_wr(8'h02, 8'hC0); mem_wr(8'h03, 8'h00);
    run(cyc);
    chk("R3", "cycles", cyc, 8);
    chk("R3", "no illegal", illegal, 0);
    rd_reg(4'h7, v); chk("R3", "r7", v, 8'h4D);
    rd_mem(8'h10, v); mem_wr(8'h10, 8'hA5);
    rd_mem(8'h10, v); chk("R13", "debug mem write", v, 8'hA5);
  endtask

  initial begin
    t_reset_idle();
    t_example();
    t_wrap_same_reg_illegal();
    t_all_illegal();
    t_fetch_order();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule